// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block gathers 64 level-sensitive interrupt request lines. It sends each one either to a normal interrupt output or to a fast interrupt output. Software drives it over a simple register bus: a byte address, write data, a write enable and combinational read data. Each source has its own enable bit, a type bit that picks normal or fast, and a 4-bit priority.

Normal requests must also pass a 5-bit priority threshold. The controller then picks a single winner from the normal requests. Two status words report the winning normal source with its priority, and the pending fast source. A 64-word table of handler addresses is stored next to the control state, and software can read and write it.

Sources are enabled and disabled by writing a source number to a register set aside for each action, so no read-modify-write is needed. Priority fields are packed eight to a word, and the packing runs in reverse word order.

Top module: `vic_top`

## Requirements
- R1: After reset, every enable, type, priority, threshold, control bit and table word is zero. Both outputs are low. The normal status word (0x40) reads 0xFFFF0000 and the fast status word (0x44) reads 0xFFFFFFFF.
- R2: Bit 0 of the control word at 0x00 is read/write, and writing 0 clears it. The threshold at 0x04 is 5 bits wide, read/write.
- R3: Table word n is at 0x100 + 4*n and is a 32-bit read/write word. Unmapped addresses read as zero.
- R4: Writing a number below 64 to 0x08 sets that source's enable bit. Writing it to 0x0C clears the bit. No other source changes, and numbers of 64 or more are ignored. Enables for sources 0..31 read back at 0x10 and for sources 32..63 at 0x14, bit i = source i.
- R5: The type word at 0x18 holds sources 0..31 and the one at 0x1C holds sources 32..63, bit i = source i. A 1 makes a source fast and a 0 makes it normal.
- R6: Priority word k is at 0x20 + 4*k, for k from 0 to 7. It holds source n, where k = 7 - (n >> 3), in bits [(n & 7)*4 +: 4].
- R7: A source is a normal candidate when it is requesting, enabled, typed normal, and its priority is below the threshold, so a threshold of 0x1F passes all levels. The highest priority wins, and on a tie the higher source number wins. The word at 0x40 then reads {index[15:0], 12'b0, priority[3:0]}, or 0xFFFF0000 when there is no candidate. The normal output is high exactly when a candidate exists.
- R8: The word at 0x44 reads the highest-numbered source that is requesting, enabled and typed fast, or 0xFFFFFFFF when there is none. Priority and threshold have no effect on it. The fast output is high exactly when such a source exists.
- R9: Both status words and both outputs are registered. Each one reflects the requests and register state present before the clock edge that loads it, which is one edge after a change on the request lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqSrc | input | 64 | Level request lines, bit i = source i |
| busAddr | input | 10 | Byte address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write enable, sampled on the rising clock edge |
| busRdata | output | 32 | Combinational read data for busAddr |
| irqOut | output | 1 | Normal interrupt output |
| fiqOut | output | 1 | Fast interrupt output |

## Verification
A register write takes effect at the clock edge that samples it, and reads return data in the same cycle as the address. The status words and outputs are loaded one edge after the requests and register state they depend on. A change on the request lines therefore appears after one edge, and a register write appears after two. The bench drives inputs on falling edges and waits two rising edges before it reads the status words and samples the outputs, so every result it checks is settled. One directed check samples the normal output just before and just after the single edge that should raise it.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_SRC  = 64;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int PRIO_W   = 4;
  localparam int THR_W    = PRIO_W + 1;
  localparam int PER_WORD = 32 / PRIO_W;
  localparam int PWORDS   = NUM_SRC / PER_WORD;
  localparam int PW_W     = $clog2(PWORDS);
  localparam int LANE_W   = $clog2(PER_WORD);
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 10;

  typedef enum logic [3:0] {
    RD_NONE, RD_CTRL, RD_THR, RD_ENLO, RD_ENHI, RD_TYLO, RD_TYHI,
    RD_PRIO, RD_NSTAT, RD_FSTAT, RD_VEC
  } rdSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrThr;
    logic wrEnNum;
    logic wrDisNum;
    logic wrTypeLo;
    logic wrTypeHi;
    logic wrPrio;
    logic wrVec;
    rdSel_e rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (busAddr[ADDR_W-1:8] == 2'b01) begin
      stb.rdSel = RD_VEC;
      stb.idx   = busAddr[IDX_W+1:2];
      stb.wrVec = busWe;
    end else if (busAddr[ADDR_W-1:8] == 2'b00) begin
      if (busAddr[7:5] == 3'b001) begin
        stb.rdSel  = RD_PRIO;
        stb.idx    = IDX_W'(busAddr[PW_W+1:2]);
        stb.wrPrio = busWe;
      end else begin
        case (busAddr[7:0])
          8'h00: begin stb.rdSel = RD_CTRL; stb.wrCtrl = busWe; end
          8'h04: begin stb.rdSel = RD_THR;  stb.wrThr  = busWe; end
          8'h08: stb.wrEnNum  = busWe;
          8'h0C: stb.wrDisNum = busWe;
          8'h10: stb.rdSel = RD_ENLO;
          8'h14: stb.rdSel = RD_ENHI;
          8'h18: begin stb.rdSel = RD_TYLO; stb.wrTypeLo = busWe; end
          8'h1C: begin stb.rdSel = RD_TYHI; stb.wrTypeHi = busWe; end
          8'h40: stb.rdSel = RD_NSTAT;
          8'h44: stb.rdSel = RD_FSTAT;
          default: stb.rdSel = RD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqSrc,
  input  logic [DATA_W-1:0]  busWdata,
  input  strobe_t            stb,
  output logic [DATA_W-1:0]  busRdata,
  output logic [DATA_W-1:0]  nStatus,
  output logic [DATA_W-1:0]  fStatus,
  output logic [NUM_SRC-1:0] enMask,
  output logic [NUM_SRC-1:0] typeMask,
  output logic               irqOut,
  output logic               fiqOut
);
  localparam int HALF = NUM_SRC / 2;

  logic              ctrlQ;
  logic [THR_W-1:0]  thrQ;
  logic [PRIO_W-1:0] prioQ [NUM_SRC];
  logic [DATA_W-1:0] vecQ  [NUM_SRC];

  wire numOk = (busWdata < DATA_W'(NUM_SRC));
  wire [IDX_W-1:0] numIdx = busWdata[IDX_W-1:0];
  wire [PW_W-1:0]  pword  = stb.idx[PW_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= 1'b0;
      thrQ     <= '0;
      enMask   <= '0;
      typeMask <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        prioQ[i] <= '0;
        vecQ[i]  <= '0;
      end
    end else begin
      if (stb.wrCtrl) ctrlQ <= busWdata[0];
      if (stb.wrThr)  thrQ  <= busWdata[THR_W-1:0];
      if (stb.wrEnNum && numOk)  enMask[numIdx] <= 1'b1;
      if (stb.wrDisNum && numOk) enMask[numIdx] <= 1'b0;
      if (stb.wrTypeLo) typeMask[HALF-1:0]       <= busWdata[HALF-1:0];
      if (stb.wrTypeHi) typeMask[NUM_SRC-1:HALF] <= busWdata[HALF-1:0];
      if (stb.wrPrio)
        for (int j = 0; j < PER_WORD; j++)
          prioQ[{~pword, LANE_W'(j)}] <= busWdata[j*PRIO_W +: PRIO_W];
      if (stb.wrVec) vecQ[stb.idx] <= busWdata;
    end
  end

  logic              nValid, fValid;
  logic [IDX_W-1:0]  nIdx, fIdx;
  logic [PRIO_W-1:0] nPrio;

  always_comb begin
    nValid = 1'b0; nIdx = '0; nPrio = '0;
    fValid = 1'b0; fIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (irqSrc[i] && enMask[i] && !typeMask[i] &&
          ({1'b0, prioQ[i]} < thrQ) && (!nValid || prioQ[i] >= nPrio)) begin
        nValid = 1'b1; nIdx = IDX_W'(i); nPrio = prioQ[i];
      end
      if (irqSrc[i] && enMask[i] && typeMask[i]) begin
        fValid = 1'b1; fIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nStatus <= 32'hFFFF_0000;
      fStatus <= '1;
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
    end else begin
      nStatus <= nValid ? {16'(nIdx), 12'b0, nPrio} : 32'hFFFF_0000;
      fStatus <= fValid ? DATA_W'(fIdx) : '1;
      irqOut  <= nValid;
      fiqOut  <= fValid;
    end
  end

  always_comb begin
    busRdata = '0;
    case (stb.rdSel)
      RD_CTRL:  busRdata = DATA_W'(ctrlQ);
      RD_THR:   busRdata = DATA_W'(thrQ);
      RD_ENLO:  busRdata = enMask[HALF-1:0];
      RD_ENHI:  busRdata = enMask[NUM_SRC-1:HALF];
      RD_TYLO:  busRdata = typeMask[HALF-1:0];
      RD_TYHI:  busRdata = typeMask[NUM_SRC-1:HALF];
      RD_PRIO:
        for (int j = 0; j < PER_WORD; j++)
          busRdata[j*PRIO_W +: PRIO_W] = prioQ[{~pword, LANE_W'(j)}];
      RD_NSTAT: busRdata = nStatus;
      RD_FSTAT: busRdata = fStatus;
      RD_VEC:   busRdata = vecQ[stb.idx];
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   irqSrc,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 busWe,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 irqOut,
  output logic                 fiqOut
);
  strobe_t            stb;
  logic [DATA_W-1:0]  nStatus, fStatus;
  logic [NUM_SRC-1:0] enMask, typeMask;

  vic_ctrl ctrl_i (.busAddr(busAddr), .busWe(busWe), .stb(stb));

  vic_datapath dp_i (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .busWdata(busWdata), .stb(stb),
    .busRdata(busRdata), .nStatus(nStatus), .fStatus(fStatus),
    .enMask(enMask), .typeMask(typeMask), .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqSrc,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic               busWe,
  input logic [DATA_W-1:0]  nStatus,
  input logic [DATA_W-1:0]  fStatus,
  input logic [NUM_SRC-1:0] enMask,
  input logic [NUM_SRC-1:0] typeMask,
  input logic               irqOut,
  input logic               fiqOut
);
  wire [IDX_W-1:0] nIdx = nStatus[16 +: IDX_W];
  wire [IDX_W-1:0] fIdx = fStatus[IDX_W-1:0];

  // R7: normal output agrees with the normal status word
  assert_irq_matches_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (nStatus[31:16] != 16'hFFFF));

  // R8: fast output agrees with the fast status word
  assert_fiq_matches_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut == (fStatus != '1));

  // R7 / R9: reported normal winner was a requesting, enabled, normal-typed source
  assert_normal_winner_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(irqSrc & enMask & ~typeMask) >> nIdx) & 64'd1);

  // R8 / R9: reported fast source was requesting, enabled and fast-typed
  assert_fast_source_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> ($past(irqSrc & enMask & typeMask) >> fIdx) & 64'd1);

  // R4: enable-number write sets the named bit
  assert_enable_sets_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 10'h008 && busWdata < 32'd64) |=> enMask[$past(busWdata[IDX_W-1:0])]);

  // R4: disable-number write clears the named bit
  assert_disable_clears_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 10'h00C && busWdata < 32'd64) |=> !enMask[$past(busWdata[IDX_W-1:0])]);
endmodule

bind vic_top vic_checker chk_i (
  .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .busAddr(busAddr), .busWdata(busWdata),
  .busWe(busWe), .nStatus(nStatus), .fStatus(fStatus), .enMask(enMask),
  .typeMask(typeMask), .irqOut(irqOut), .fiqOut(fiqOut)
);

// File: tb/vic_top_tb.sv
module vic_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqSrc = '0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic        mEn [64];
  logic        mTy [64];
  logic [3:0]  mPr [64];
  logic [4:0]  mThr;

  always #4 clk = ~clk;

  vic_top dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  function automatic logic [31:0] expNormal(input logic [63:0] s);
    logic [31:0] r = 32'hFFFF_0000;
    logic        v = 1'b0;
    logic [3:0]  bp = '0;
    for (int i = 0; i < 64; i++)
      if (s[i] && mEn[i] && !mTy[i] && ({1'b0, mPr[i]} < mThr) && (!v || mPr[i] >= bp)) begin
        v = 1'b1; bp = mPr[i]; r = {16'(i), 12'b0, mPr[i]};
      end
    return r;
  endfunction

  function automatic logic [31:0] expFast(input logic [63:0] s);
    logic [31:0] r = '1;
    for (int i = 0; i < 64; i++)
      if (s[i] && mEn[i] && mTy[i]) r = 32'(i);
    return r;
  endfunction

  task automatic setEn(input int n, input bit on);
    wr(on ? 10'h008 : 10'h00C, 32'(n));
    if (n < 64) mEn[n] = on;
  endtask

  task automatic setPrioWord(input int k, input logic [31:0] v);
    wr(10'(32'h20 + 4*k), v);
    for (int j = 0; j < 8; j++) mPr[(7-k)*8 + j] = v[j*4 +: 4];
  endtask

  task automatic setType(input bit hi, input logic [31:0] v);
    wr(hi ? 10'h01C : 10'h018, v);
    for (int j = 0; j < 32; j++) mTy[(hi ? 32 : 0) + j] = v[j];
  endtask

  task automatic checkStatus(input string tag);
    logic [31:0] en, ef;
    en = expNormal(irqSrc); ef = expFast(irqSrc);
    repeat (2) @(posedge clk);
    rdChk({tag, " R7 normal status"}, 10'h040, en);
    rdChk({tag, " R8 fast status"}, 10'h044, ef);
    check({tag, " R7 irqOut"}, 32'(irqOut), 32'(en[31:16] != 16'hFFFF));
    check({tag, " R8 fiqOut"}, 32'(fiqOut), 32'(ef != '1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) begin mEn[i] = 0; mTy[i] = 0; mPr[i] = 0; end
    mThr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 fiqOut", 32'(fiqOut), 0);
    rdChk("R1 normal status", 10'h040, 32'hFFFF_0000);
    rdChk("R1 fast status", 10'h044, 32'hFFFF_FFFF);
    rdChk("R1 threshold", 10'h004, 0);
    rdChk("R1 enables", 10'h014, 0);
    rdChk("R1 prio word", 10'h03C, 0);
    rdChk("R1 table", 10'h1FC, 0);

    // R2 control and threshold
    wr(10'h000, 32'hFFFF_FFFF); rdChk("R2 ctrl set", 10'h000, 1);
    wr(10'h000, 0);             rdChk("R2 ctrl clear", 10'h000, 0);
    wr(10'h004, 32'hFFFF_FFFF); mThr = 5'h1F; rdChk("R2 threshold", 10'h004, 32'h1F);

    // R3 table and unmapped
    wr(10'h100, 32'hDEAD_BEEF); wr(10'h1FC, 32'h1234_5678);
    rdChk("R3 table first", 10'h100, 32'hDEAD_BEEF);
    rdChk("R3 table last", 10'h1FC, 32'h1234_5678);
    rdChk("R3 table other", 10'h104, 0);
    rdChk("R3 unmapped", 10'h048, 0);

    // R4 enable by number, out of range ignored
    setEn(0, 1); setEn(63, 1); setEn(33, 1);
    wr(10'h008, 32'd64); wr(10'h008, 32'h0000_0101);
    rdChk("R4 enables lo", 10'h010, 32'h0000_0001);
    rdChk("R4 enables hi", 10'h014, 32'h8000_0002);
    setEn(33, 0); wr(10'h00C, 32'd64);
    rdChk("R4 disable hi", 10'h014, 32'h8000_0000);

    // R5 type registers
    setType(0, 32'hA5A5_0001); setType(1, 32'h0000_8000);
    rdChk("R5 type lo", 10'h018, 32'hA5A5_0001);
    rdChk("R5 type hi", 10'h01C, 32'h0000_8000);
    setType(0, 0); setType(1, 0);

    // R6 priority packing: source 63 -> word 0 bits 31:28; source 0 -> word 7 bits 3:0
    setPrioWord(0, 32'h9000_0000); setPrioWord(7, 32'h0000_0003);
    rdChk("R6 word0", 10'h020, 32'h9000_0000);
    rdChk("R6 word7", 10'h03C, 32'h0000_0003);
    irqSrc = 64'h8000_0000_0000_0001;
    checkStatus("R6 placement");

    // R7 tie favours higher index
    setPrioWord(0, 32'h3000_0000);
    checkStatus("R7 tie");
    // R7 threshold blocks priority 3 when threshold is 3
    wr(10'h004, 3); mThr = 3;
    checkStatus("R7 threshold");
    wr(10'h004, 32'h1F); mThr = 5'h1F;

    // R8 fast ignores priority and threshold
    setType(1, 32'h8000_0000); wr(10'h004, 0); mThr = 0;
    checkStatus("R8 fast");
    wr(10'h004, 32'h1F); mThr = 5'h1F; setType(1, 0);

    // R9 single-edge latency on the normal output
    irqSrc = '0; repeat (2) @(posedge clk);
    @(negedge clk) irqSrc = 64'h1;
    #1 check("R9 before edge", 32'(irqOut), 0);
    @(posedge clk); #1 check("R9 after edge", 32'(irqOut), 1);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 6;
      case (op)
        0, 1: setEn($urandom % 66, 1);
        2:    setEn($urandom % 64, 0);
        3:    setType($urandom % 2, $urandom & $urandom & $urandom);
        4:    setPrioWord($urandom % 8, $urandom);
        default: begin
          logic [4:0] t = ($urandom % 3 == 0) ? 5'($urandom) : 5'h1F;
          wr(10'h004, 32'(t)); mThr = t;
        end
      endcase
      @(negedge clk) irqSrc = {$urandom, $urandom} & {$urandom, $urandom};
      checkStatus("R7 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule